// File: doc/BRIEF.md
# Calendar Timekeeper with Deferred Commit

This block holds the wall-clock time of day and the calendar date as two packed words. Both words advance once for every pulse of a one-per-second enable that runs in the core clock domain. A small register port gives access to three words: a control/status word, a date word and a time word. Reads are combinational. Writes to the time or date word go into a staging slot rather than straight into the counters.

A staged value is loaded into the counters on the next second pulse after the write. Until then, a busy bit in the control word stays set: one bit for the time word and one for the date word. Software polls the group of busy bits before it writes, so it never overwrites a commit that is still in flight.

The date word holds a year offset from 1970, which covers 1970 to 2033, together with an explicit leap-year flag. The calendar logic uses this flag when February ends. When the year advances, the block computes the flag again.

Top module: `cal_timekeeper`

## Requirements
- R1: After reset, the time word reads 0x00000000, the date word reads 0x00000101 (day 1, month 1, year offset 0, leap flag 0) and the control word reads 0x00000000.
- R2: The seconds field advances by one on each cycle where tick_i is high. Neither word changes in a cycle where tick_i is low.
- R3: The time word packs seconds in bits 5:0, minutes in bits 13:8 and hours in bits 20:16. Seconds roll from 59 to 0 and carry into minutes. Minutes roll from 59 to 0 and carry into hours. Hours roll from 23 to 0 and advance the date by one day.
- R4: The date word packs day in bits 4:0, month (1 to 12) in bits 11:8, year offset in bits 21:16 and the leap flag in bit 22. A day advance past the last day of the month gives day 1 of the next month. Months 4, 6, 9 and 11 have 30 days. All other months except 2 have 31 days.
- R5: February has 29 days when the leap flag is 1 and 28 days when it is 0.
- R6: An advance past December 31 gives January 1, with the year offset increased by one. The leap flag becomes 1 exactly when (new offset + 1970) mod 4 is 0.
- R7: A write to the time word (address 0x14) sets control bit 8 and leaves the time word unchanged. On the next tick, the time word takes the written value and bit 8 clears.
- R8: A write to the date word (address 0x10) sets control bit 7 and leaves the date word unchanged. On the next tick, the date word takes the written value and bit 7 clears.
- R9: A second write to a word whose busy bit is still set replaces the staged value. Only the last value written is committed.
- R10: Unused bits of the time and date words read as zero after a commit. Control bit 9 and every other control bit apart from bits 8:7 read as zero. Writes to the control word or to unmapped addresses have no effect. Unmapped addresses read as zero.
- R11: A write in the same cycle as a tick is not committed on that tick. The counters advance normally on that tick, the busy bit stays set, and the commit happens on the following tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse once per second |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |

## Verification
The counting function is driven from start values placed just before each boundary: end of a minute, end of an hour, end of a day, 30-day and 31-day months, February in leap and non-leap years, and year end. Each case separates one carry path or one month-length branch from the others. The year-end cases land on both a leap and a non-leap new year, which exercises the flag computation and not just the year increment. The commit path is tried with a plain write, a double write, a write that coincides with a tick, and all-ones data. These cases separate deferral, last-write-wins, tick ordering and field masking.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int unsigned YEAR_BASE = 1970;
  localparam logic [7:0] ADDR_CTRL = 8'h00;
  localparam logic [7:0] ADDR_DATE = 8'h10;
  localparam logic [7:0] ADDR_TIME = 8'h14;
  localparam int unsigned BIT_DATE_BUSY = 7;
  localparam int unsigned BIT_TIME_BUSY = 8;
  localparam logic [31:0] TIME_MASK = 32'h001F_3F3F;
  localparam logic [31:0] DATE_MASK = 32'h007F_0F1F;

  typedef struct packed {
    logic [4:0] hour;
    logic [5:0] min;
    logic [5:0] sec;
  } tod_t;

  typedef struct packed {
    logic       leap;
    logic [5:0] year;
    logic [3:0] mon;
    logic [4:0] day;
  } cal_t;

  function automatic logic [31:0] tod_pack(tod_t t);
    return {11'b0, t.hour, 2'b0, t.min, 2'b0, t.sec};
  endfunction

  function automatic tod_t tod_unpack(logic [31:0] w);
    tod_t t;
    t.hour = w[20:16];
    t.min  = w[13:8];
    t.sec  = w[5:0];
    return t;
  endfunction

  function automatic logic [31:0] cal_pack(cal_t c);
    return {9'b0, c.leap, c.year, 4'b0, c.mon, 3'b0, c.day};
  endfunction

  function automatic cal_t cal_unpack(logic [31:0] w);
    cal_t c;
    c.leap = w[22];
    c.year = w[21:16];
    c.mon  = w[11:8];
    c.day  = w[4:0];
    return c;
  endfunction
endpackage

// File: rtl/cal_stage.sv
module cal_stage #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         tick_i,
  output logic         busy_o,
  output logic         load_o,
  output logic [W-1:0] pend_o
);
  logic         busy_q;
  logic [W-1:0] pend_q;

  // a write in the tick cycle wins over the commit
  assign load_o = busy_q & tick_i & ~wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      pend_q <= '0;
    end else if (wr_i) begin
      busy_q <= 1'b1;
      pend_q <= wdata_i;
    end else if (load_o) begin
      busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/cal_tod_cnt.sv
module cal_tod_cnt
  import cal_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic load_i,
  input  tod_t load_val_i,
  output tod_t tod_o,
  output logic day_carry_o
);
  tod_t tod_q, tod_d;
  logic sec_end, min_end, hour_end;

  assign sec_end  = (tod_q.sec == 6'd59);
  assign min_end  = (tod_q.min == 6'd59);
  assign hour_end = (tod_q.hour == 5'd23);

  always_comb begin
    tod_d = tod_q;
    if (load_i) begin
      tod_d = load_val_i;
    end else if (tick_i) begin
      tod_d.sec = sec_end ? 6'd0 : tod_q.sec + 6'd1;
      if (sec_end) begin
        tod_d.min = min_end ? 6'd0 : tod_q.min + 6'd1;
        if (min_end) tod_d.hour = hour_end ? 5'd0 : tod_q.hour + 5'd1;
      end
    end
  end

  assign day_carry_o = tick_i & ~load_i & sec_end & min_end & hour_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tod_q <= '0;
    else         tod_q <= tod_d;
  end

  assign tod_o = tod_q;
endmodule

// File: rtl/cal_date_cnt.sv
module cal_date_cnt
  import cal_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  input  logic load_i,
  input  cal_t load_val_i,
  output cal_t cal_o
);
  cal_t       cal_q, cal_d;
  logic [4:0] mon_len;
  logic [5:0] year_nx;
  logic [10:0] year_abs;

  always_comb begin
    unique case (cal_q.mon)
      4'd2:                       mon_len = cal_q.leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:    mon_len = 5'd30;
      default:                    mon_len = 5'd31;
    endcase
  end

  assign year_nx  = cal_q.year + 6'd1;
  assign year_abs = 11'(YEAR_BASE) + {5'b0, year_nx};

  always_comb begin
    cal_d = cal_q;
    if (load_i) begin
      cal_d = load_val_i;
    end else if (adv_i) begin
      if (cal_q.day >= mon_len) begin
        cal_d.day = 5'd1;
        if (cal_q.mon >= 4'd12) begin
          cal_d.mon  = 4'd1;
          cal_d.year = year_nx;
          cal_d.leap = (year_abs[1:0] == 2'b00);
        end else begin
          cal_d.mon = cal_q.mon + 4'd1;
        end
      end else begin
        cal_d.day = cal_q.day + 5'd1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cal_q <= '{leap: 1'b0, year: 6'd0, mon: 4'd1, day: 5'd1};
    else         cal_q <= cal_d;
  end

  assign cal_o = cal_q;
endmodule

// File: rtl/cal_timekeeper.sv
module cal_timekeeper
  import cal_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic        wr_time, wr_date;
  logic        time_busy, date_busy, time_load, date_load;
  logic [31:0] time_pend, date_pend;
  logic [31:0] time_word, date_word, ctrl_word;
  logic        day_carry;
  tod_t        tod;
  cal_t        cal;

  assign wr_time = we_i & (addr_i == ADDR_W'(ADDR_TIME));
  assign wr_date = we_i & (addr_i == ADDR_W'(ADDR_DATE));

  cal_stage #(.W(32)) u_time_stage (
    .clk_i, .rst_ni, .wr_i(wr_time), .wdata_i(wdata_i[31:0] & TIME_MASK),
    .tick_i, .busy_o(time_busy), .load_o(time_load), .pend_o(time_pend)
  );

  cal_stage #(.W(32)) u_date_stage (
    .clk_i, .rst_ni, .wr_i(wr_date), .wdata_i(wdata_i[31:0] & DATE_MASK),
    .tick_i, .busy_o(date_busy), .load_o(date_load), .pend_o(date_pend)
  );

  cal_tod_cnt u_tod (
    .clk_i, .rst_ni, .tick_i, .load_i(time_load),
    .load_val_i(tod_unpack(time_pend)), .tod_o(tod), .day_carry_o(day_carry)
  );

  cal_date_cnt u_date (
    .clk_i, .rst_ni, .adv_i(day_carry), .load_i(date_load),
    .load_val_i(cal_unpack(date_pend)), .cal_o(cal)
  );

  assign time_word = tod_pack(tod);
  assign date_word = cal_pack(cal);

  always_comb begin
    ctrl_word = '0;
    ctrl_word[BIT_TIME_BUSY] = time_busy;
    ctrl_word[BIT_DATE_BUSY] = date_busy;
  end

  always_comb begin
    unique case (addr_i)
      ADDR_W'(ADDR_CTRL): rdata_o = DATA_W'(ctrl_word);
      ADDR_W'(ADDR_DATE): rdata_o = DATA_W'(date_word);
      ADDR_W'(ADDR_TIME): rdata_o = DATA_W'(time_word);
      default:            rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/cal_timekeeper_chk.sv
module cal_timekeeper_chk
  import cal_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        tick_i,
  input logic        we_i,
  input logic [7:0]  addr_i,
  input logic [31:0] wdata_i,
  input logic        time_busy,
  input logic        date_busy,
  input logic [31:0] time_pend,
  input logic [31:0] date_pend,
  input logic [31:0] time_word,
  input logic [31:0] date_word
);
  logic c_wr_time, c_wr_date;
  assign c_wr_time = we_i && addr_i == ADDR_TIME;
  assign c_wr_date = we_i && addr_i == ADDR_DATE;

  assert_time_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(time_word));

  assert_sec_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !time_busy && time_word[5:0] == 6'd59 |=> time_word[5:0] == 6'd0);

  assert_tbusy_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    time_busy && !tick_i |=> time_busy);

  assert_tcommit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    time_busy && tick_i && !c_wr_time |=> !time_busy && time_word == $past(time_pend));

  assert_date_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(date_word));

  assert_dcommit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    date_busy && tick_i && !c_wr_date |=> !date_busy && date_word == $past(date_pend));

  assert_restage_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_wr_time |=> time_busy && time_pend == ($past(wdata_i) & TIME_MASK));

  assert_tick_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_wr_date && tick_i |=> date_busy);
endmodule

bind cal_timekeeper cal_timekeeper_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .we_i(we_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .time_busy(time_busy),
  .date_busy(date_busy), .time_pend(time_pend), .date_pend(date_pend),
  .time_word(time_word), .date_word(date_word)
);

// File: tb/tb_cal_timekeeper.sv
`timescale 1ns/1ps
module tb_cal_timekeeper;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        we_i = 1'b0;
  logic [7:0]  addr_i = 8'h00;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  cal_timekeeper dut (
    .clk_i, .rst_ni, .tick_i, .we_i, .addr_i, .wdata_i, .rdata_o
  );

  localparam logic [7:0] A_CTRL = 8'h00, A_DATE = 8'h10, A_TIME = 8'h14;

  function automatic logic [31:0] mk_time(int h, int m, int s);
    return {11'b0, 5'(h), 2'b0, 6'(m), 2'b0, 6'(s)};
  endfunction

  function automatic logic [31:0] mk_date(int y, int mo, int d, int l);
    return {9'b0, 1'(l), 6'(y), 4'b0, 4'(mo), 3'b0, 5'(d)};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    addr_i = a;
    #1 v = rdata_o;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic tick_n(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); tick_i = 1'b1;
      @(negedge clk_i); tick_i = 1'b0;
    end
  endtask

  task automatic set_now(logic [31:0] d, logic [31:0] t);
    wr(A_TIME, t);
    wr(A_DATE, d);
    tick_n(1);
  endtask

  task automatic t_reset();
    rd_chk("R1 time", A_TIME, 32'h0);
    rd_chk("R1 date", A_DATE, 32'h0000_0101);
    rd_chk("R1 ctrl", A_CTRL, 32'h0);
  endtask

  task automatic t_count();
    tick_n(5);
    rd_chk("R2 five ticks", A_TIME, mk_time(0, 0, 5));
    repeat (7) @(negedge clk_i);
    rd_chk("R2 idle time", A_TIME, mk_time(0, 0, 5));
    rd_chk("R2 idle date", A_DATE, mk_date(0, 1, 1, 0));
  endtask

  task automatic t_carry();
    set_now(mk_date(0, 1, 1, 0), mk_time(0, 59, 59));
    tick_n(1);
    rd_chk("R3 hour carry", A_TIME, mk_time(1, 0, 0));
    set_now(mk_date(0, 1, 1, 0), mk_time(13, 0, 59));
    tick_n(1);
    rd_chk("R3 minute carry", A_TIME, mk_time(13, 1, 0));
    set_now(mk_date(0, 1, 1, 0), mk_time(23, 59, 59));
    tick_n(1);
    rd_chk("R3 day wrap time", A_TIME, mk_time(0, 0, 0));
    rd_chk("R3 day wrap date", A_DATE, mk_date(0, 1, 2, 0));
  endtask

  task automatic t_month();
    set_now(mk_date(3, 4, 30, 0), mk_time(23, 59, 59));
    tick_n(1);
    rd_chk("R4 april end", A_DATE, mk_date(3, 5, 1, 0));
    set_now(mk_date(3, 1, 30, 0), mk_time(23, 59, 59));
    tick_n(1);
    rd_chk("R4 jan 30 to 31", A_DATE, mk_date(3, 1, 31, 0));
    set_now(mk_date(3, 1, 31, 0), mk_time(23, 59, 59));
    tick_n(1);
    rd_chk("R4 jan end", A_DATE, mk_date(3, 2, 1, 0));
  endtask

  task automatic t_feb();
    set_now(mk_date(2, 2, 28, 1), mk_time(23, 59, 59));
    tick_n(1);
    rd_chk("R5 leap feb 29", A_DATE, mk_date(2, 2, 29, 1));
    set_now(mk_date(2, 2, 29, 1), mk_time(23, 59, 59));
    tick_n(1);
    rd_chk("R5 leap feb end", A_DATE, mk_date(2, 3, 1, 1));
    set_now(mk_date(3, 2, 28, 0), mk_time(23, 59, 59));
    tick_n(1);
    rd_chk("R5 plain feb end", A_DATE, mk_date(3, 3, 1, 0));
  endtask

  task automatic t_year();
    set_now(mk_date(5, 12, 31, 0), mk_time(23, 59, 59));
    tick_n(1);
    rd_chk("R6 into leap year", A_DATE, mk_date(6, 1, 1, 1));
    set_now(mk_date(6, 12, 31, 1), mk_time(23, 59, 59));
    tick_n(1);
    rd_chk("R6 out of leap year", A_DATE, mk_date(7, 1, 1, 0));
  endtask

  task automatic t_time_commit();
    set_now(mk_date(0, 1, 1, 0), mk_time(0, 0, 0));
    wr(A_TIME, mk_time(7, 8, 9));
    rd_chk("R7 busy set", A_CTRL, 32'h0000_0100);
    repeat (4) @(negedge clk_i);
    rd_chk("R7 deferred", A_TIME, mk_time(0, 0, 0));
    tick_n(1);
    rd_chk("R7 committed", A_TIME, mk_time(7, 8, 9));
    rd_chk("R7 busy clear", A_CTRL, 32'h0);
  endtask

  task automatic t_date_commit();
    wr(A_DATE, mk_date(20, 6, 15, 0));
    rd_chk("R8 busy set", A_CTRL, 32'h0000_0080);
    rd_chk("R8 deferred", A_DATE, mk_date(0, 1, 1, 0));
    tick_n(1);
    rd_chk("R8 committed", A_DATE, mk_date(20, 6, 15, 0));
    rd_chk("R8 busy clear", A_CTRL, 32'h0);
  endtask

  task automatic t_rewrite();
    wr(A_TIME, mk_time(1, 0, 0));
    wr(A_TIME, mk_time(2, 0, 0));
    rd_chk("R9 still busy", A_CTRL, 32'h0000_0100);
    tick_n(1);
    rd_chk("R9 last write wins", A_TIME, mk_time(2, 0, 0));
  endtask

  task automatic t_tick_write();
    set_now(mk_date(0, 1, 1, 0), mk_time(0, 0, 10));
    @(negedge clk_i);
    we_i = 1'b1; addr_i = A_TIME; wdata_i = mk_time(0, 30, 0); tick_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0; tick_i = 1'b0;
    rd_chk("R11 counted normally", A_TIME, mk_time(0, 0, 11));
    rd_chk("R11 busy held", A_CTRL, 32'h0000_0100);
    tick_n(1);
    rd_chk("R11 committed next tick", A_TIME, mk_time(0, 30, 0));
  endtask

  task automatic t_unused();
    set_now(mk_date(0, 1, 1, 0), mk_time(0, 0, 0));
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd_chk("R10 ctrl write ignored", A_CTRL, 32'h0);
    wr(8'h18, 32'hFFFF_FFFF);
    rd_chk("R10 unmapped write time", A_TIME, mk_time(0, 0, 0));
    rd_chk("R10 unmapped write date", A_DATE, mk_date(0, 1, 1, 0));
    rd_chk("R10 unmapped read", 8'h08, 32'h0);
    wr(A_TIME, 32'hFFFF_FFFF);
    wr(A_DATE, 32'hFFFF_FFFF);
    rd_chk("R10 bit9 clear", A_CTRL, 32'h0000_0180);
    tick_n(1);
    rd_chk("R10 time mask", A_TIME, 32'h001F_3F3F);
    rd_chk("R10 date mask", A_DATE, 32'h007F_0F1F);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_count();
    t_carry();
    t_month();
    t_feb();
    t_year();
    t_time_commit();
    t_date_commit();
    t_rewrite();
    t_tick_write();
    t_unused();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule